// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the per-line horizontal timing for an interline CCD from one pixel clock (nominally 12.27 MHz, about 81.5 ns per clock). A free-running line counter spans 1560 clocks, numbered 1 to 1560. A horizontal sync pulse is driven high from the wrap of the counter through clock 156.

Every clock of the line is labelled with the readout segment it belongs to. There are four segments, in a fixed order: a dummy pre-scan stretch, a short leading optical-black reference, the active pixels, and a trailing optical-black reference. During the active segment the block raises a valid strobe and gives a zero-based column index. It also gives a colour tag taken from a two-row mosaic. On one row type the pattern is red and green; on the other it is green and blue. Which row type applies is set by a row-parity input from the vertical side.

The start of the pre-scan is a parameter. Its default puts the whole 1372-clock sequence just after the sync pulse, within the line.

Top module: `ccd_hline_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `line_cnt` = 1 and `hd` = 1.
- R2: Outside reset, `line_cnt` rises by one each clock. From 1560 it returns to 1.
- R3: `hd` is 1 exactly when `line_cnt` is in 1..156.
- R4: `seg` is 1 (pre-scan) for counts 157..184, 2 (leading black) for 185..187, 3 (active) for 188..1479 and 4 (trailing black) for 1480..1528. Every other count gives 0 (idle).
- R5: `act_valid` is 1 exactly when `seg` is 3, so each line has 1292 valid clocks.
- R6: While `act_valid` is 1, `act_col` runs 0 to 1291 and rises by one each clock. While `act_valid` is 0, `act_col` is 0.
- R7: `bayer` uses R=0, G=1, B=2. With `row_parity` 0, even columns give R and odd columns give G. With `row_parity` 1, even columns give G and odd columns give B. While `act_valid` is 0, `bayer` is 3.
- R8: `row_parity` has no effect on `line_cnt`, `hd`, `seg`, `act_valid` or `act_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| row_parity | input | 1 | Parity of the current sensor row (0 = red/green row) |
| line_cnt | output | 11 | Clock position in the line, 1..1560 |
| hd | output | 1 | Horizontal sync pulse |
| seg | output | 3 | Segment code: 0 idle, 1 pre-scan, 2 leading black, 3 active, 4 trailing black |
| act_valid | output | 1 | Active pixel strobe |
| act_col | output | 11 | Active column index |
| bayer | output | 2 | Colour tag of the current pixel |

## Verification
The hardest case to reach is a reset in the middle of a line, together with a row-parity change in the middle of a line. After such a reset, the counter must resume at 1 and the segment boundaries must still fall at their fixed counts. The stimulus runs whole lines on both row parities. It toggles the parity inside the black and active segments, and it pulses reset deep inside the active segment. A cycle-accurate model predicts every output clock by clock across these events.

// File: rtl/ccd_hline_pkg.sv
package ccd_hline_pkg;

    typedef enum logic [2:0] {
        SEG_IDLE      = 3'd0,
        SEG_PRESCAN   = 3'd1,
        SEG_BLK_LEAD  = 3'd2,
        SEG_ACTIVE    = 3'd3,
        SEG_BLK_TRAIL = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        PIX_R    = 2'd0,
        PIX_G    = 2'd1,
        PIX_B    = 2'd2,
        PIX_NONE = 2'd3
    } pix_color_e;

    typedef struct packed {
        seg_e seg;
        logic valid;
    } seg_info_t;

    localparam int NUM_SEG = 4;

    // colour of a valid pixel from column and row parity
    function automatic pix_color_e mosaic_color(input logic col_odd, input logic row_odd);
        if (!row_odd) return col_odd ? PIX_G : PIX_R;
        else          return col_odd ? PIX_B : PIX_G;
    endfunction

endpackage

// File: rtl/hl_line_counter.sv
module hl_line_counter #(
    parameter int LINE_LEN = 1560,
    parameter int HD_END   = 156,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             hd
);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(LINE_LEN);
    localparam logic [CNT_W-1:0] HDLIM = CNT_W'(HD_END);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (cnt == LAST) cnt_nxt = FIRST;
        else             cnt_nxt = cnt + FIRST;
    end

    // hd is registered from the next count so it leaves the block glitch free
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= FIRST;
            hd  <= 1'b1;
        end else begin
            cnt <= cnt_nxt;
            hd  <= (cnt_nxt <= HDLIM);
        end
    end
endmodule

// File: rtl/hl_segment_decode.sv
module hl_segment_decode
    import ccd_hline_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int COL_W     = 11,
    parameter int PRE_START = 157,
    parameter int PRE_LEN   = 28,
    parameter int OBF_LEN   = 3,
    parameter int ACT_LEN   = 1292,
    parameter int OBR_LEN   = 49
) (
    input  logic [CNT_W-1:0] cnt,
    output seg_info_t        info,
    output logic [COL_W-1:0] col
);
    localparam int S_PRE = PRE_START;
    localparam int S_OBF = S_PRE + PRE_LEN;
    localparam int S_ACT = S_OBF + OBF_LEN;
    localparam int S_OBR = S_ACT + ACT_LEN;
    localparam int SEG_FIRST [NUM_SEG] = '{S_PRE, S_OBF, S_ACT, S_OBR};
    localparam int SEG_SIZE  [NUM_SEG] = '{PRE_LEN, OBF_LEN, ACT_LEN, OBR_LEN};
    localparam logic [CNT_W-1:0] ACT_BASE = CNT_W'(S_ACT);

    logic [NUM_SEG-1:0] hit;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [CNT_W-1:0] LO = CNT_W'(SEG_FIRST[g]);
        localparam logic [CNT_W-1:0] HI = CNT_W'(SEG_FIRST[g] + SEG_SIZE[g] - 1);
        assign hit[g] = (cnt >= LO) && (cnt <= HI);
    end

    logic [CNT_W-1:0] offs;

    always_comb begin
        info.seg = SEG_IDLE;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (hit[i]) info.seg = seg_e'(3'(i + 1));
        end
        info.valid = hit[2];
        offs       = cnt - ACT_BASE;
        col        = hit[2] ? COL_W'(offs) : '0;
    end
endmodule

// File: rtl/hl_mosaic.sv
module hl_mosaic
    import ccd_hline_pkg::*;
(
    input  logic       valid,
    input  logic       col_odd,
    input  logic       row_odd,
    output pix_color_e color
);
    always_comb begin
        if (valid) color = mosaic_color(col_odd, row_odd);
        else       color = PIX_NONE;
    end
endmodule

// File: rtl/ccd_hline_gen.sv
module ccd_hline_gen
    import ccd_hline_pkg::*;
#(
    parameter int LINE_LEN  = 1560,
    parameter int HD_END    = 156,
    parameter int PRE_START = 157,
    parameter int PRE_LEN   = 28,
    parameter int OBF_LEN   = 3,
    parameter int ACT_LEN   = 1292,
    parameter int OBR_LEN   = 49,
    localparam int CNT_W    = $clog2(LINE_LEN + 1),
    localparam int COL_W    = $clog2(ACT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_parity,
    output logic [CNT_W-1:0] line_cnt,
    output logic             hd,
    output logic [2:0]       seg,
    output logic             act_valid,
    output logic [COL_W-1:0] act_col,
    output logic [1:0]       bayer
);
    seg_info_t  info;
    pix_color_e color;

    hl_line_counter #(
        .LINE_LEN(LINE_LEN), .HD_END(HD_END), .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .cnt(line_cnt), .hd(hd)
    );

    hl_segment_decode #(
        .CNT_W(CNT_W), .COL_W(COL_W), .PRE_START(PRE_START), .PRE_LEN(PRE_LEN),
        .OBF_LEN(OBF_LEN), .ACT_LEN(ACT_LEN), .OBR_LEN(OBR_LEN)
    ) u_seg (
        .cnt(line_cnt), .info(info), .col(act_col)
    );

    hl_mosaic u_mos (
        .valid(info.valid), .col_odd(act_col[0]), .row_odd(row_parity), .color(color)
    );

    assign seg       = info.seg;
    assign act_valid = info.valid;
    assign bayer     = color;
endmodule

// File: rtl/ccd_hline_chk.sv
module ccd_hline_chk #(
    parameter int LINE_LEN = 1560,
    parameter int CNT_W    = 11,
    parameter int COL_W    = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             row_parity,
    input logic [CNT_W-1:0] line_cnt,
    input logic             hd,
    input logic [2:0]       seg,
    input logic             act_valid,
    input logic [COL_W-1:0] act_col,
    input logic [1:0]       bayer
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (line_cnt == CNT_W'(1)) && hd);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == CNT_W'(LINE_LEN)) |=> (line_cnt == CNT_W'(1)));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (line_cnt != CNT_W'(LINE_LEN)) |=> (line_cnt == CNT_W'($past(line_cnt) + CNT_W'(1))));

    assert_hd_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hd) |-> (line_cnt == CNT_W'(1)));

    assert_valid_seg_R5: assert property (@(posedge clk) disable iff (rst)
        act_valid == (seg == 3'd3));

    assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
        (act_valid && $past(act_valid)) |-> (act_col == COL_W'($past(act_col) + COL_W'(1))));

    assert_col_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !act_valid |-> (act_col == '0));

    assert_color_R7: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> (bayer == {row_parity & act_col[0], row_parity ^ act_col[0]}));

    assert_color_none_R7: assert property (@(posedge clk) disable iff (rst)
        !act_valid |-> (bayer == 2'd3));
endmodule

bind ccd_hline_gen ccd_hline_chk #(
    .LINE_LEN(LINE_LEN), .CNT_W(CNT_W), .COL_W(COL_W)
) u_chk (
    .clk(clk), .rst(rst), .row_parity(row_parity), .line_cnt(line_cnt), .hd(hd),
    .seg(seg), .act_valid(act_valid), .act_col(act_col), .bayer(bayer)
);

// File: tb/sim_ccd_hline_gen.sv
module sim_ccd_hline_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        row_parity = 1'b0;
    logic [10:0] line_cnt;
    logic        hd;
    logic [2:0]  seg;
    logic        act_valid;
    logic [10:0] act_col;
    logic [1:0]  bayer;

    int checks = 0;
    int errors = 0;
    int m = 1;

    typedef struct {
        int cnt; int hd; int seg; int v; int col; int clr;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    ccd_hline_gen u0 (
        .clk(clk), .rst(rst), .row_parity(row_parity), .line_cnt(line_cnt), .hd(hd),
        .seg(seg), .act_valid(act_valid), .act_col(act_col), .bayer(bayer)
    );

    function automatic exp_t model(int c, int rp);
        exp_t e;
        e.cnt = c;
        e.hd  = (c <= 156) ? 1 : 0;
        if (c >= 157 && c <= 184)       e.seg = 1;
        else if (c >= 185 && c <= 187)  e.seg = 2;
        else if (c >= 188 && c <= 1479) e.seg = 3;
        else if (c >= 1480 && c <= 1528) e.seg = 4;
        else                            e.seg = 0;
        e.v   = (e.seg == 3) ? 1 : 0;
        e.col = e.v ? c - 188 : 0;
        if (!e.v)          e.clr = 3;
        else if (rp == 0)  e.clr = (e.col % 2 == 0) ? 0 : 1;
        else               e.clr = (e.col % 2 == 0) ? 1 : 2;
        return e;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at model count %0d: actual %0d expected %0d", req, m, act, exp);
        end
    endtask

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R2 line_cnt", int'(line_cnt), e.cnt);
            chk("R3 hd", int'(hd), e.hd);
            chk("R4 seg", int'(seg), e.seg);
            chk("R5 act_valid", int'(act_valid), e.v);
            chk("R6 act_col", int'(act_col), e.col);
            chk("R7 bayer", int'(bayer), e.clr);
        end
    end

    task automatic step(int rp);
        row_parity = rp[0];
        q.push_back(model(m, rp));
        @(negedge clk);
        m = (m == 1560) ? 1 : m + 1;
    endtask

    task automatic run(int n, int rp);
        for (int i = 0; i < n; i++) step(rp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset line_cnt", int'(line_cnt), 1);
        chk("R1 reset hd", int'(hd), 1);
        rst = 1'b0;
        m = 1;
        run(1560, 0);               // full even row: R,G
        run(1560, 1);               // full odd row: G,B
        // R8: parity toggled inside black and active segments
        run(186, 0);
        run(2, 1);
        run(200, 0);
        for (int i = 0; i < 40; i++) step(i % 3 == 0 ? 1 : 0);
        run(1560 - 428 + 5, 1);     // wrap into next line
        // R1: mid-line reset deep in the active segment
        run(900, 0);
        rst = 1'b1;
        q.push_back(model(m, 0));
        @(negedge clk);
        rst = 1'b0;
        m = 1;
        run(1600, 1);
        wait (q.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule